// File: doc/BRIEF.md
# Spindle Mode and Manual Sequence Controller

This block holds the operating mode of a three-phase sensorless spindle driver and decides when the six-state phase sequencer may advance. It moves between five modes (tristate, startup, run, park and brake) under control of an output-enable level, a run/stop level, a nominal-speed indication from the speed loop and a timeout from the brake-delay timer. From the current mode and the output enable it derives three driver commands: all outputs high-impedance, all low-side switches on, and a low-power park flag.

The phase sequencer takes advance requests from two sources. The first is the internal startup engine, which is accepted only while the motor is being started or is running. The second is a host processor that steps the phases by hand with rising edges on an asynchronous strobe. Host edges are synchronized, spaced by a minimum number of clock cycles, and can be disabled by a level input. When both sources request in the same cycle, the host edge is issued first and the internal request one cycle later, so no step is lost. A small detector compares back-EMF zero crossings with the issued steps and clears a monotonicity flag when exactly two crossings fall between consecutive steps.

Startup timing and commutation delay generation sit outside this block.

Top module: `spindle_mode_ctrl`

## Requirements
- R1: After reset the mode is tristate, `hiz_o` is 1, `brake_o`, `park_o` and `seq_inc_o` are 0, and `mono_flag_o` is 1.
- R2: While `out_en_i` is 0, `hiz_o` is 1 and `brake_o` is 0 in every mode, in the same cycle.
- R3: A rising edge of `run_i` (high now, low on the previous clock) with `out_en_i` high, seen in tristate, park or brake, moves the mode to startup at that clock edge. The same edge with `out_en_i` low leaves the mode unchanged.
- R4: In startup, `at_speed_i` high moves the mode to run at the next clock edge.
- R5: A falling edge of `run_i` in startup or run moves the mode to park. In park, `park_o` and `hiz_o` are 1.
- R6: Park is held until `brake_tmo_i` is high, which moves the mode to brake. In brake with `out_en_i` high, `brake_o` is 1 and `hiz_o` is 0.
- R7: Each accepted rising edge of `step_i` gives one single-cycle `seq_inc_o` pulse, SYNC_STAGES+1 clock edges after the first edge that samples the new level. Host edges are accepted in tristate, startup and run, and ignored in park and brake.
- R8: A host edge arriving fewer than MIN_GAP_CYC cycles after the previous accepted host edge is ignored; one arriving exactly MIN_GAP_CYC cycles later is accepted.
- R9: While `step_dis_i` is 1, host edges are ignored and `mono_flag_o` is 1 from the next clock edge on.
- R10: A high `su_adv_i` in startup or run gives a `seq_inc_o` pulse at the next clock edge. In tristate, park and brake it is ignored.
- R11: When an accepted host edge and an accepted internal request fall in the same cycle, the host pulse is issued first and the internal pulse in the following cycle.
- R12: At each `seq_inc_o` pulse, `mono_flag_o` becomes 0 if exactly two `zc_i` pulses arrived since the previous pulse, and 1 otherwise.
- R13: `mode_o` is one-hot: tristate = 5'b00001, startup = 5'b00010, run = 5'b00100, park = 5'b01000, brake = 5'b10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_en_i | input | 1 | Power stage enable level |
| run_i | input | 1 | Run (1) or stop (0) request |
| step_i | input | 1 | Asynchronous host step strobe, rising-edge active |
| step_dis_i | input | 1 | Disables host stepping and the monotonicity detector |
| brake_tmo_i | input | 1 | Brake-delay timer expired |
| su_adv_i | input | 1 | Advance request from the internal startup engine |
| at_speed_i | input | 1 | Motor has reached nominal speed |
| zc_i | input | 1 | Back-EMF zero-crossing pulse |
| mode_o | output | 5 | One-hot current mode |
| hiz_o | output | 1 | All power outputs high-impedance |
| brake_o | output | 1 | All low-side drivers on |
| park_o | output | 1 | Park / sleep phase active |
| seq_inc_o | output | 1 | Single-cycle sequencer advance |
| mono_flag_o | output | 1 | Monotonicity flag, 0 when crossings are twice the step rate |

## Verification
The mode machine is driven through a full cycle: a run edge with enable low, then a start, nominal speed, stop, park, timeout, brake and restart. Output enable is dropped in startup and in brake, which shows that the enable overrides both the driving and the braking commands. Host strobes are sent at exactly the minimum spacing and at half of it, which tells the spacing limit apart from an off-by-one. A host edge and an internal request are made to coincide, which shows whether the arbiter defers or drops the internal step. Runs of one and of two zero crossings between steps tell the monotonicity condition apart from a plain any-crossing test.

// File: rtl/spm_pkg.sv
package spm_pkg;

   localparam int MODE_W = 5;

   typedef enum logic [MODE_W-1:0] {
      M_TRI   = 5'b00001,
      M_START = 5'b00010,
      M_RUN   = 5'b00100,
      M_PARK  = 5'b01000,
      M_BRAKE = 5'b10000
   } spm_mode_e;

endpackage

// File: rtl/spm_mode_fsm.sv
module spm_mode_fsm
   import spm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      out_en_i,
   input  logic      run_i,
   input  logic      at_speed_i,
   input  logic      brake_tmo_i,
   output spm_mode_e mode_o,
   output logic      hiz_o,
   output logic      brake_o,
   output logic      park_o
);

   spm_mode_e mode_q, mode_d;
   logic      run_q;
   logic      run_rise, run_fall;

   assign run_rise = run_i & ~run_q;
   assign run_fall = ~run_i & run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_TRI;
         run_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         run_q  <= run_i;
      end
   end

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         M_TRI: begin
            if (run_rise && out_en_i) mode_d = M_START;
         end
         M_START: begin
            if (run_fall)        mode_d = M_PARK;
            else if (at_speed_i) mode_d = M_RUN;
         end
         M_RUN: begin
            if (run_fall) mode_d = M_PARK;
         end
         M_PARK: begin
            if (run_rise && out_en_i) mode_d = M_START;
            else if (brake_tmo_i)     mode_d = M_BRAKE;
         end
         M_BRAKE: begin
            if (run_rise && out_en_i) mode_d = M_START;
         end
         default: mode_d = M_TRI;
      endcase
   end

   assign mode_o  = mode_q;
   assign park_o  = (mode_q == M_PARK);
   assign brake_o = (mode_q == M_BRAKE) & out_en_i;
   assign hiz_o   = ~out_en_i | (mode_q == M_TRI) | (mode_q == M_PARK);

endmodule

// File: rtl/spm_step_gate.sv
module spm_step_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_GAP     = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic dis_i,
   input  logic allow_i,
   output logic acc_o
);

   localparam int GAP_W = (MIN_GAP > 1) ? $clog2(MIN_GAP + 1) : 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spm_step_gate: SYNC_STAGES must be at least 2");
      end
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("spm_step_gate: MIN_GAP must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   edge_w;
   logic                   gap_ok;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= step_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_w = sync_q[SYNC_STAGES-1] & ~last_q;
   assign acc_o  = edge_w & ~dis_i & allow_i & gap_ok;

   generate
      if (MIN_GAP > 1) begin : g_spacing
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             gap_q <= '0;
            else if (acc_o)         gap_q <= GAP_W'(MIN_GAP - 1);
            else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
         end
         assign gap_ok = (gap_q == '0);
      end else begin : g_no_spacing
         assign gap_ok = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/spm_inc_arb.sv
module spm_inc_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic host_i,
   input  logic int_i,
   input  logic int_allow_i,
   output logic fire_o,
   output logic seq_inc_o
);

   logic pend_q, pend_d;
   logic int_req;

   assign int_req = int_i & int_allow_i;

   always_comb begin
      fire_o = 1'b0;
      pend_d = pend_q & int_allow_i;
      if (host_i) begin
         fire_o = 1'b1;
         pend_d = (pend_q & int_allow_i) | int_req;
      end else if (pend_q && int_allow_i) begin
         fire_o = 1'b1;
         pend_d = int_req;
      end else if (int_req) begin
         fire_o = 1'b1;
         pend_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         seq_inc_o <= 1'b0;
      end else begin
         pend_q    <= pend_d;
         seq_inc_o <= fire_o;
      end
   end

endmodule

// File: rtl/spm_mono_det.sv
module spm_mono_det #(
   parameter int CNT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zc_i,
   input  logic fire_i,
   input  logic dis_i,
   output logic mono_o
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("spm_mono_det: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

   logic [CNT_W-1:0] zc_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_cnt_q <= '0;
         mono_o   <= 1'b1;
      end else if (dis_i) begin
         zc_cnt_q <= '0;
         mono_o   <= 1'b1;
      end else if (fire_i) begin
         zc_cnt_q <= '0;
         mono_o   <= (zc_cnt_q != CNT_TWO);
      end else if (zc_i && zc_cnt_q != CNT_MAX) begin
         zc_cnt_q <= zc_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spindle_mode_ctrl.sv
module spindle_mode_ctrl
   import spm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_GAP_CYC = 200,
   parameter int ZC_CNT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_en_i,
   input  logic              run_i,
   input  logic              step_i,
   input  logic              step_dis_i,
   input  logic              brake_tmo_i,
   input  logic              su_adv_i,
   input  logic              at_speed_i,
   input  logic              zc_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              hiz_o,
   output logic              brake_o,
   output logic              park_o,
   output logic              seq_inc_o,
   output logic              mono_flag_o
);

   spm_mode_e mode_w;
   logic      host_allow, int_allow;
   logic      host_acc, fire_w;

   spm_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .out_en_i    (out_en_i),
      .run_i       (run_i),
      .at_speed_i  (at_speed_i),
      .brake_tmo_i (brake_tmo_i),
      .mode_o      (mode_w),
      .hiz_o       (hiz_o),
      .brake_o     (brake_o),
      .park_o      (park_o)
   );

   assign host_allow = (mode_w == M_TRI) | (mode_w == M_START) | (mode_w == M_RUN);
   assign int_allow  = (mode_w == M_START) | (mode_w == M_RUN);

   spm_step_gate #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_GAP     (MIN_GAP_CYC)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step_i),
      .dis_i   (step_dis_i),
      .allow_i (host_allow),
      .acc_o   (host_acc)
   );

   spm_inc_arb u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_i      (host_acc),
      .int_i       (su_adv_i),
      .int_allow_i (int_allow),
      .fire_o      (fire_w),
      .seq_inc_o   (seq_inc_o)
   );

   spm_mono_det #(
      .CNT_W (ZC_CNT_W)
   ) u_mono (
      .clk    (clk),
      .rst_n  (rst_n),
      .zc_i   (zc_i),
      .fire_i (fire_w),
      .dis_i  (step_dis_i),
      .mono_o (mono_flag_o)
   );

   assign mode_o = mode_w;

endmodule

// File: rtl/spm_ctrl_chk.sv
module spm_ctrl_chk
   import spm_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              out_en_i,
   input logic              run_i,
   input logic              step_dis_i,
   input logic              brake_tmo_i,
   input logic [MODE_W-1:0] mode_o,
   input logic              hiz_o,
   input logic              brake_o,
   input logic              seq_inc_o,
   input logic              mono_flag_o
);

   // R2
   enable_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_i |-> (hiz_o && !brake_o));

   // R13
   mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_o) == 1);

   // R6
   park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == M_PARK && !brake_tmo_i && !run_i) |=> (mode_o == M_PARK));

   // R7
   no_step_in_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == M_PARK || $past(mode_o) == M_BRAKE) |-> !seq_inc_o);

   // R9
   mono_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_dis_i |=> mono_flag_o);

endmodule

bind spindle_mode_ctrl spm_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .out_en_i    (out_en_i),
   .run_i       (run_i),
   .step_dis_i  (step_dis_i),
   .brake_tmo_i (brake_tmo_i),
   .mode_o      (mode_o),
   .hiz_o       (hiz_o),
   .brake_o     (brake_o),
   .seq_inc_o   (seq_inc_o),
   .mono_flag_o (mono_flag_o)
);

// File: tb/spindle_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module spindle_mode_ctrl_tb_top;

   localparam int SYNC = 2;
   localparam int GAP  = 20;

   localparam logic [4:0] TRI_M   = 5'b00001;
   localparam logic [4:0] START_M = 5'b00010;
   localparam logic [4:0] RUN_M   = 5'b00100;
   localparam logic [4:0] PARK_M  = 5'b01000;
   localparam logic [4:0] BRAKE_M = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic out_en_i = 1'b0, run_i = 1'b0, step_i = 1'b0, step_dis_i = 1'b0;
   logic brake_tmo_i = 1'b0, su_adv_i = 1'b0, at_speed_i = 1'b0, zc_i = 1'b0;
   logic [4:0] mode_o;
   logic hiz_o, brake_o, park_o, seq_inc_o, mono_flag_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   int exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spindle_mode_ctrl #(
      .SYNC_STAGES (SYNC),
      .MIN_GAP_CYC (GAP),
      .ZC_CNT_W    (3)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .out_en_i(out_en_i), .run_i(run_i),
      .step_i(step_i), .step_dis_i(step_dis_i), .brake_tmo_i(brake_tmo_i),
      .su_adv_i(su_adv_i), .at_speed_i(at_speed_i), .zc_i(zc_i),
      .mode_o(mode_o), .hiz_o(hiz_o), .brake_o(brake_o), .park_o(park_o),
      .seq_inc_o(seq_inc_o), .mono_flag_o(mono_flag_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Monitor: every pulse must match the front of the expected queue
   always @(negedge clk) begin
      if (rst_n && seq_inc_o === 1'b1) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R7/R10/R11 unexpected pulse: actual cycle %0d expected none", cyc);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != cyc) begin
               fails++;
               $display("FAIL R7/R10/R11 pulse cycle: actual %0d expected %0d", cyc, e);
            end
         end
      end
   end

   // host rising edge; ok means a pulse is expected SYNC+1 edges later
   task automatic host_step(input bit ok);
      step_i = 1'b1;
      if (ok) exp_q.push_back(cyc + SYNC + 1);
      repeat (3) tick();
      step_i = 1'b0;
      repeat (3) tick();
   endtask

   task automatic int_adv(input bit ok);
      su_adv_i = 1'b1;
      if (ok) exp_q.push_back(cyc + 1);
      tick();
      su_adv_i = 1'b0;
      tick();
   endtask

   task automatic zc_pulse();
      zc_i = 1'b1;
      tick();
      zc_i = 1'b0;
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 mode", mode_o, TRI_M);
      chk("R1 hiz", hiz_o, 1);
      chk("R1 brake", brake_o, 0);
      chk("R1 park", park_o, 0);
      chk("R1 seq_inc", seq_inc_o, 0);
      chk("R1 mono", mono_flag_o, 1);

      // R3: run edge with enable low does nothing
      run_i = 1'b1;
      tick();
      chk("R3 no start without enable", mode_o, TRI_M);
      run_i = 1'b0;
      tick();
      out_en_i = 1'b1;
      tick();
      chk("R3 tristate hiz", hiz_o, 1);

      // R10: internal advance ignored in tristate
      int_adv(1'b0);
      chk("R10 ignored in tristate", seq_inc_o, 0);

      // R7: host step in tristate
      host_step(1'b1);
      repeat (25) tick();

      // R3: start
      run_i = 1'b1;
      tick();
      chk("R3 start", mode_o, START_M);
      chk("R3 driving", hiz_o, 0);

      // R10 internal advance, R12 monotonicity
      zc_pulse();
      zc_pulse();
      int_adv(1'b1);
      chk("R12 two crossings clear flag", mono_flag_o, 0);
      zc_pulse();
      int_adv(1'b1);
      chk("R12 one crossing sets flag", mono_flag_o, 1);

      // R8 spacing: exact gap accepted, half gap rejected
      host_step(1'b1);
      repeat (GAP - 6) tick();
      host_step(1'b1);
      repeat (GAP/2 - 6) tick();
      host_step(1'b0);
      repeat (30) tick();

      // R11 collision
      step_i = 1'b1;
      exp_q.push_back(cyc + SYNC + 1);
      tick();
      tick();
      su_adv_i = 1'b1;
      exp_q.push_back(cyc + 2);
      tick();
      su_adv_i = 1'b0;
      tick();
      step_i = 1'b0;
      repeat (30) tick();

      // R9 disable
      zc_pulse();
      zc_pulse();
      int_adv(1'b1);
      chk("R12 flag clear before disable", mono_flag_o, 0);
      step_dis_i = 1'b1;
      tick();
      chk("R9 flag forced", mono_flag_o, 1);
      host_step(1'b0);
      repeat (5) tick();
      step_dis_i = 1'b0;
      repeat (25) tick();

      // R2 enable low in startup
      out_en_i = 1'b0;
      tick();
      chk("R2 hiz in startup", hiz_o, 1);
      chk("R2 mode kept", mode_o, START_M);
      out_en_i = 1'b1;
      tick();

      // R4
      at_speed_i = 1'b1;
      tick();
      at_speed_i = 1'b0;
      chk("R4 run", mode_o, RUN_M);

      // R5
      run_i = 1'b0;
      tick();
      chk("R5 park mode", mode_o, PARK_M);
      chk("R5 park flag", park_o, 1);
      chk("R5 park hiz", hiz_o, 1);
      host_step(1'b0);
      int_adv(1'b0);
      chk("R7 R10 still park", mode_o, PARK_M);

      // R6
      brake_tmo_i = 1'b1;
      tick();
      brake_tmo_i = 1'b0;
      chk("R6 brake mode", mode_o, BRAKE_M);
      chk("R6 brake on", brake_o, 1);
      chk("R6 not hiz", hiz_o, 0);
      out_en_i = 1'b0;
      tick();
      chk("R2 brake off when disabled", brake_o, 0);
      chk("R2 hiz in brake", hiz_o, 1);
      out_en_i = 1'b1;
      tick();

      // R3 restart from brake
      run_i = 1'b1;
      tick();
      chk("R3 restart from brake", mode_o, START_M);

      repeat (10) tick();
      chk("R7/R10/R11 all pulses seen", exp_q.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule